// File: doc/BRIEF.md
# Panel Command Bus Engine

This block sends single index (command) words and data words to an external display panel over a parallel, chip-select based bus. It also reads single words back from the panel. Software first loads a word register, then writes a start register. That one start write launches a bus cycle and chooses the main or the sub panel. A busy flag in the status register stays set until the cycle has finished, so software polls it between steps.

Each bus cycle has three phases, each lasting a programmable number of clocks. In the setup phase, the chip select, the register-select line and the write data are presented. In the strobe phase, the write or read strobe is held low. In the hold phase, the strobe is released while the chip select stays asserted. A read cycle samples the panel's data bus on the last clock of the strobe phase. The captured value is returned in the low 18 bits of the read register.

Top module: `panel_cmd_engine`

## Requirements
- R1: After reset the status word reads 0, both chip selects are high (1), both strobes are high, the output enable is low and the read register reads 0.
- R2: With word register bit 28 set and bit 24 clear, a write start sends an index cycle: register-select is low and the data bus carries word bits 17:0 for the whole cycle.
- R3: With word register bits 28 and 24 both set, a write start sends a data cycle with register-select high.
- R4: A start write with bit 0 set launches a cycle. Bit 1 set picks the sub panel (`pnl_cs_n[1]` low) and bit 1 clear picks the main panel (`pnl_cs_n[0]` low). A start write with bit 0 clear launches nothing.
- R5: Status bit 1 reads 1 for exactly setup+strobe+hold clocks, starting with the clock after the start write, and reads 0 otherwise.
- R6: The strobe goes low after the setup clocks, stays low for exactly the strobe clocks and is followed by the hold clocks. Write and read strobes are never low together.
- R7: The timing register holds setup in bits 3:0, strobe width in bits 7:4 and hold in bits 11:8. It reads back as written, resets to 2, 4 and 2, and a field of 0 acts as 1.
- R8: Writing the read register sets the register-select level of later reads from bit 24. A read start (bit 0 set, bit 1 choosing the panel) runs a cycle with the read strobe and the output enable low.
- R9: The read register returns the panel data sampled on the last strobe clock in bits 17:0, with bits 31:18 reading 0.
- R10: A start written while busy is ignored: the running cycle, its panel and its busy length are unchanged, and no second cycle follows.
- R11: A write start is ignored while word register bit 28 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (0 word, 1 write start, 2 read, 3 read start, 4 status, 5 timing) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| pnl_cs_n | output | 2 | Active-low chip selects, bit 0 main panel, bit 1 sub panel |
| pnl_rs | output | 1 | Register select, 0 index, 1 data |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_dout | output | 18 | Data driven toward the panel |
| pnl_oe | output | 1 | Drive enable for pnl_dout |
| pnl_din | input | 18 | Data returned by the panel |

## Verification
A phase counter stuck or miscounted shows up on the status word and the strobe pins within the same cycle, as a busy window or strobe pulse of the wrong length. A wrongly latched cycle descriptor shows up as the wrong chip select or register-select level from the first setup clock on. A capture taken on the wrong clock shows up only after the cycle has ended, on the next read of the read register. The panel model therefore changes its data on every strobe clock, so that an off-by-one capture returns a different value.

// File: rtl/panel_cmd_pkg.sv
// Shared definitions for the panel command bus engine: register map,
// flag bit positions, phase encoding and the latched cycle descriptor.
package panel_cmd_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_WORD   = 3'd0;
    localparam logic [REG_AW-1:0] A_WGO    = 3'd1;
    localparam logic [REG_AW-1:0] A_RDREG  = 3'd2;
    localparam logic [REG_AW-1:0] A_RGO    = 3'd3;
    localparam logic [REG_AW-1:0] A_STATUS = 3'd4;
    localparam logic [REG_AW-1:0] A_TIMING = 3'd5;

    localparam int CMD_FLAG_BIT = 28;
    localparam int DAT_FLAG_BIT = 24;
    localparam int GO_BIT       = 0;
    localparam int SUB_BIT      = 1;
    localparam int BUSY_BIT     = 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

    typedef struct packed {
        logic rd;
        logic sub;
        logic rs;
    } xfer_t;

endpackage

// File: rtl/panel_cmd_regs.sv
// Register file of the panel command engine.
// Holds the outgoing word, the read setup flag, captured read data and the
// timing fields. Decodes start writes into a one-cycle launch request.
// Assumes: reg_wr is a single-cycle qualified write; reads are combinational.
module panel_cmd_regs
    import panel_cmd_pkg::*;
#(
    parameter int DW     = 18,
    parameter int TW     = 4,
    parameter int RST_SU = 2,
    parameter int RST_ST = 4,
    parameter int RST_HD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              cap_vld,
    input  logic [DW-1:0]     cap_data,
    output logic              launch,
    output xfer_t             launch_cfg,
    output logic [DW-1:0]     out_word,
    output logic [TW-1:0]     t_su,
    output logic [TW-1:0]     t_st,
    output logic [TW-1:0]     t_hd
);

    localparam int TIME_W = 3 * TW;

    logic [31:0]     word_q;
    logic            rd_rs_q;
    logic [DW-1:0]   rd_cap_q;
    logic [TW-1:0]   su_q, st_q, hd_q;
    logic            is_wgo, is_rgo;

    // Decode which start register, if any, is written this cycle.
    always_comb begin
        is_wgo = reg_wr && (reg_addr == A_WGO);
        is_rgo = reg_wr && (reg_addr == A_RGO);
    end

    // Launch request: idle engine, go bit set, write cycle needs the command flag.
    always_comb begin
        launch = !busy && reg_wdata[GO_BIT] &&
                 ((is_wgo && word_q[CMD_FLAG_BIT]) || is_rgo);
        launch_cfg.rd  = is_rgo;
        launch_cfg.sub = reg_wdata[SUB_BIT];
        launch_cfg.rs  = is_rgo ? rd_rs_q : word_q[DAT_FLAG_BIT];
    end

    // Word, read setup and timing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            rd_rs_q <= 1'b0;
            su_q    <= TW'(RST_SU);
            st_q    <= TW'(RST_ST);
            hd_q    <= TW'(RST_HD);
        end else if (reg_wr) begin
            case (reg_addr)
                A_WORD:   word_q  <= reg_wdata;
                A_RDREG:  rd_rs_q <= reg_wdata[DAT_FLAG_BIT];
                A_TIMING: begin
                    su_q <= reg_wdata[TW-1:0];
                    st_q <= reg_wdata[2*TW-1:TW];
                    hd_q <= reg_wdata[3*TW-1:2*TW];
                end
                default: ;
            endcase
        end
    end

    // Captured read data from the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_cap_q <= '0;
        else if (cap_vld) rd_cap_q <= cap_data;
    end

    // Effective timing: a zero field behaves as one clock.
    always_comb begin
        t_su = (su_q == '0) ? TW'(1) : su_q;
        t_st = (st_q == '0) ? TW'(1) : st_q;
        t_hd = (hd_q == '0) ? TW'(1) : hd_q;
    end

    assign out_word = word_q[DW-1:0];

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_WORD:   reg_rdata = word_q;
            A_RDREG:  reg_rdata[DW-1:0] = rd_cap_q;
            A_STATUS: reg_rdata[BUSY_BIT] = busy;
            A_TIMING: reg_rdata[TIME_W-1:0] = {hd_q, st_q, su_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/panel_cmd_seq.sv
// Bus cycle sequencer: setup, strobe and hold phases of programmable length.
// Latches panel, direction, register-select, data and timing at launch so
// later register writes cannot disturb a running cycle.
// Assumes: launch only arrives while idle; timing inputs are at least 1.
module panel_cmd_seq
    import panel_cmd_pkg::*;
#(
    parameter int DW = 18,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  xfer_t         launch_cfg,
    input  logic [DW-1:0] word,
    input  logic [TW-1:0] t_su,
    input  logic [TW-1:0] t_st,
    input  logic [TW-1:0] t_hd,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic [1:0]    cs_n,
    output logic          rs,
    output logic          wr_n,
    output logic          rd_n,
    output logic [DW-1:0] dout,
    output logic          oe,
    output logic          cap_vld,
    output logic [DW-1:0] cap_data
);

    phase_t        ph;
    logic [TW-1:0] cnt;
    logic [TW-1:0] lim_su, lim_st, lim_hd;
    logic [TW-1:0] limit;
    logic          last;
    xfer_t         cur;
    logic [DW-1:0] dat;

    // Phase length for the current phase and end-of-phase flag.
    always_comb begin
        case (ph)
            PH_SETUP:  limit = lim_su;
            PH_STROBE: limit = lim_st;
            default:   limit = lim_hd;
        endcase
        last = (cnt == limit);
    end

    // Phase state machine and in-phase clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (launch) begin
                    ph  <= PH_SETUP;
                    cnt <= TW'(1);
                end
                PH_SETUP: if (last) begin
                    ph  <= PH_STROBE;
                    cnt <= TW'(1);
                end else cnt <= cnt + TW'(1);
                PH_STROBE: if (last) begin
                    ph  <= PH_HOLD;
                    cnt <= TW'(1);
                end else cnt <= cnt + TW'(1);
                default: if (last) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + TW'(1);
            endcase
        end
    end

    // Cycle descriptor, data and timing latched at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            dat    <= '0;
            lim_su <= TW'(1);
            lim_st <= TW'(1);
            lim_hd <= TW'(1);
        end else if (ph == PH_IDLE && launch) begin
            cur    <= launch_cfg;
            dat    <= word;
            lim_su <= t_su;
            lim_st <= t_st;
            lim_hd <= t_hd;
        end
    end

    // Panel pins decoded from the registered phase.
    always_comb begin
        busy = (ph != PH_IDLE);
        cs_n = 2'b11;
        if (busy) cs_n = cur.sub ? 2'b01 : 2'b10;
        rs   = busy && cur.rs;
        wr_n = !(ph == PH_STROBE && !cur.rd);
        rd_n = !(ph == PH_STROBE && cur.rd);
        oe   = busy && !cur.rd;
        dout = oe ? dat : '0;
    end

    // Read capture on the final strobe clock.
    always_comb begin
        cap_vld  = (ph == PH_STROBE) && last && cur.rd;
        cap_data = din;
    end

endmodule

// File: rtl/panel_cmd_engine.sv
// Top of the panel command bus engine: register file plus bus sequencer.
// Assumes one register access per clock and an external panel that honours
// the programmed setup, strobe and hold times.
module panel_cmd_engine
    import panel_cmd_pkg::*;
#(
    parameter int DW     = 18,
    parameter int TW     = 4,
    parameter int RST_SU = 2,
    parameter int RST_ST = 4,
    parameter int RST_HD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [1:0]        pnl_cs_n,
    output logic              pnl_rs,
    output logic              pnl_wr_n,
    output logic              pnl_rd_n,
    output logic [DW-1:0]     pnl_dout,
    output logic              pnl_oe,
    input  logic [DW-1:0]     pnl_din
);

    logic          busy;
    logic          launch;
    xfer_t         launch_cfg;
    logic [DW-1:0] out_word;
    logic [TW-1:0] t_su, t_st, t_hd;
    logic          cap_vld;
    logic [DW-1:0] cap_data;

    panel_cmd_regs #(
        .DW(DW), .TW(TW), .RST_SU(RST_SU), .RST_ST(RST_ST), .RST_HD(RST_HD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy),
        .cap_vld(cap_vld), .cap_data(cap_data),
        .launch(launch), .launch_cfg(launch_cfg), .out_word(out_word),
        .t_su(t_su), .t_st(t_st), .t_hd(t_hd)
    );

    panel_cmd_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_cfg(launch_cfg), .word(out_word),
        .t_su(t_su), .t_st(t_st), .t_hd(t_hd), .din(pnl_din),
        .busy(busy), .cs_n(pnl_cs_n), .rs(pnl_rs),
        .wr_n(pnl_wr_n), .rd_n(pnl_rd_n), .dout(pnl_dout), .oe(pnl_oe),
        .cap_vld(cap_vld), .cap_data(cap_data)
    );

endmodule

// File: rtl/panel_cmd_engine_chk.sv
// Protocol checker for the panel command engine, bound to the top module.
// Assumes the register map of panel_cmd_pkg.
module panel_cmd_engine_chk
    import panel_cmd_pkg::*;
#(
    parameter int DW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [1:0]        pnl_cs_n,
    input logic              pnl_rs,
    input logic              pnl_wr_n,
    input logic              pnl_rd_n,
    input logic [DW-1:0]     pnl_dout,
    input logic              pnl_oe
);

    AST_ONE_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pnl_cs_n)); // R4
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pnl_wr_n && !pnl_rd_n)); // R6
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnl_wr_n || !pnl_rd_n) |-> (pnl_cs_n != 2'b11)); // R6
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rd_n |-> !pnl_oe); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n)); // R5
    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_STATUS) |-> (reg_rdata[BUSY_BIT] == busy)); // R5
    AST_RS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pnl_rs)); // R2
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pnl_dout) && $stable(pnl_cs_n))); // R10

endmodule

bind panel_cmd_engine panel_cmd_engine_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs),
    .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n), .pnl_dout(pnl_dout),
    .pnl_oe(pnl_oe)
);

// File: tb/panel_cmd_engine_test.sv
// Directed bench for the panel command engine; models the panel data bus.
module panel_cmd_engine_test;
    import panel_cmd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [REG_AW-1:0] reg_addr = A_STATUS;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [1:0]        pnl_cs_n;
    logic              pnl_rs, pnl_wr_n, pnl_rd_n, pnl_oe;
    logic [DW-1:0]     pnl_dout;
    logic [DW-1:0]     pnl_din = '0;

    int n_chk = 0;
    int n_fail = 0;

    // observations from the last cycle run
    int          o_busy, o_first, o_low, o_bad;
    logic [1:0]  o_cs;
    logic        o_rs, o_oe;
    logic [DW-1:0] o_dout;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pnl_cs_n(pnl_cs_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_dout(pnl_dout), .pnl_oe(pnl_oe), .pnl_din(pnl_din)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STATUS;
    endtask

    task automatic rreg(input logic [REG_AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_STATUS;
    endtask

    // Issue a start and watch the pins for 40 clocks. Inject a second start at sample 2.
    task automatic run(input logic [REG_AW-1:0] go, input logic [31:0] gov,
                       input bit inject, input logic [DW-1:0] base);
        o_busy = 0; o_first = 0; o_low = 0; o_bad = 0;
        o_cs = 2'b11; o_rs = 1'b0; o_oe = 1'b0; o_dout = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = go; reg_wdata = gov;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = A_STATUS;
            if (!pnl_rd_n) pnl_din = base + DW'(i);
            #1;
            if (reg_rdata[BUSY_BIT]) o_busy++;
            if (!pnl_wr_n || !pnl_rd_n) begin
                o_low++;
                if (o_first == 0) o_first = i;
            end
            if (!pnl_wr_n && go == A_RGO) o_bad++;
            if (!pnl_rd_n && go == A_WGO) o_bad++;
            if (i == 1) begin
                o_cs = pnl_cs_n; o_rs = pnl_rs; o_oe = pnl_oe; o_dout = pnl_dout;
            end else if (pnl_cs_n != 2'b11 && pnl_cs_n != o_cs) o_bad++;
            if (inject && i == 2) begin
                reg_wr = 1'b1; reg_addr = A_WGO; reg_wdata = 32'h3;
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rreg(A_STATUS, d); chk("R1 status", d, 0);
        chk("R1 cs_n", 32'(pnl_cs_n), 3);
        chk("R1 strobes/oe", {29'd0, pnl_wr_n, pnl_rd_n, pnl_oe}, 32'b110);
        rreg(A_RDREG, d); chk("R1 read reg", d, 0);
        rreg(A_TIMING, d); chk("R7 timing reset", d, 32'h242);
    endtask

    task automatic t_index_write;
        wreg(A_WORD, 32'h1000_0000 | 32'h2A5A5);
        run(A_WGO, 32'h1, 1'b0, '0);
        chk("R2 rs low", 32'(o_rs), 0);
        chk("R2 dout", 32'(o_dout), 32'h2A5A5);
        chk("R2 oe", 32'(o_oe), 1);
        chk("R4 main cs", 32'(o_cs), 2'b10);
        chk("R5 busy len", o_busy, 8);
        chk("R6 strobe start", o_first, 3);
        chk("R6 strobe len", o_low, 4);
        chk("R6 strobe kind", o_bad, 0);
    endtask

    task automatic t_data_write_sub;
        wreg(A_WORD, 32'h1100_0000 | 32'h00123);
        run(A_WGO, 32'h3, 1'b0, '0);
        chk("R3 rs high", 32'(o_rs), 1);
        chk("R3 dout", 32'(o_dout), 32'h123);
        chk("R4 sub cs", 32'(o_cs), 2'b01);
    endtask

    task automatic t_timing;
        logic [31:0] d;
        wreg(A_TIMING, 32'h111);
        run(A_WGO, 32'h1, 1'b0, '0);
        chk("R7 min busy", o_busy, 3);
        wreg(A_TIMING, 32'h753);
        rreg(A_TIMING, d); chk("R7 readback", d, 32'h753);
        run(A_WGO, 32'h1, 1'b0, '0);
        chk("R7 busy 3+5+7", o_busy, 15);
        chk("R6 strobe start 4", o_first, 4);
        chk("R6 strobe len 5", o_low, 5);
        wreg(A_TIMING, 32'h000);
        run(A_WGO, 32'h1, 1'b0, '0);
        chk("R7 zero acts as one", o_busy, 3);
        wreg(A_TIMING, 32'h242);
    endtask

    task automatic t_read;
        logic [31:0] d;
        wreg(A_RDREG, 32'h0100_0000);
        run(A_RGO, 32'h1, 1'b0, 18'h3FFFC);
        chk("R8 read rs", 32'(o_rs), 1);
        chk("R8 read oe", 32'(o_oe), 0);
        chk("R8 read strobe kind", o_bad, 0);
        chk("R8 read busy", o_busy, 8);
        rreg(A_RDREG, d);
        chk("R9 captured last strobe clock", d, 32'h00002);
        wreg(A_RDREG, 32'h0);
        run(A_RGO, 32'h3, 1'b0, 18'h01000);
        chk("R8 status read rs", 32'(o_rs), 0);
        chk("R8 sub read cs", 32'(o_cs), 2'b01);
        rreg(A_RDREG, d);
        chk("R9 second capture", d, 32'h01006);
    endtask

    task automatic t_busy_ignore;
        wreg(A_WORD, 32'h1000_0055);
        run(A_WGO, 32'h1, 1'b1, '0);
        chk("R10 busy unchanged", o_busy, 8);
        chk("R10 panel unchanged", o_bad, 0);
        chk("R10 single strobe", o_low, 4);
    endtask

    task automatic t_ignored_starts;
        run(A_WGO, 32'h2, 1'b0, '0);
        chk("R4 go bit clear", o_busy, 0);
        wreg(A_WORD, 32'h0100_0077);
        run(A_WGO, 32'h1, 1'b0, '0);
        chk("R11 no command flag", o_busy, 0);
        chk("R11 no strobe", o_low, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_index_write;
        t_data_write_sub;
        t_timing;
        t_read;
        t_busy_ignore;
        t_ignored_starts;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule